// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is a general-purpose I/O port with a small register interface. Each of the sixteen pins has an output latch, a direction bit and an interrupt-enable bit. Output levels never need a read-modify-write. Software writes a mask to a set, clear or toggle address, and only the bits written as one change. The interrupt enables work the same way, through one set address and one clear address.

Pin levels pass through a two-flop synchronizer before anything uses them. The synchronized levels can be read back through the data address. They also feed a single level-sensitive interrupt line: a pin raises it while it is an input, is enabled, and is high. The pads, any pin sharing with other functions and the interrupt controller are outside this block.

Top module: `gpio_port`

## Requirements
- R1: After reset, every output latch bit, direction bit and interrupt-enable bit is 0 (all pins are inputs), and `irq` is 0.
- R2: A write to address 1 loads the direction register, where bit value 1 makes that pin an output. `pad_oe` shows the new value from the next clock, and reads of address 1 return it.
- R3: A write to address 2 sets to 1 each output latch bit whose write-data bit is 1, and leaves every other bit unchanged.
- R4: A write to address 3 clears to 0 each output latch bit whose write-data bit is 1, and leaves every other bit unchanged.
- R5: A write to address 4 inverts each output latch bit whose write-data bit is 1, and leaves every other bit unchanged.
- R6: Reads of addresses 2, 3 and 4 return the current output latch, which is also driven on `pad_out`.
- R7: A read of address 0 returns the `pad_in` levels sampled two clock edges earlier (two-flop synchronizer).
- R8: A write to address 5 enables the interrupt of each pin whose write-data bit is 1. A write to address 6 disables each pin whose write-data bit is 1. Bits written as 0 are unchanged, and reads of either address return the enable mask.
- R9: `irq` is 1 exactly when at least one pin is an input, is enabled, and has a synchronized level of 1.
- R10: A pin whose direction bit is 1 (output) never drives `irq`, whatever its enable bit and input level.
- R11: Writes to address 0 and address 7 change no state, and reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Read data for the current address (combinational) |
| pad_in | input | 16 | Raw pin levels from the pads |
| pad_out | output | 16 | Output latch driven toward the pads |
| pad_oe | output | 16 | Output enable per pin (direction register) |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
On every cycle, the embedded assertions check the following. Each masked write changes only the bits it names, in the direction its address implies. Idle cycles and writes to the dead addresses leave the latches stable. The second synchronizer stage follows the first. `irq` stays low when no pin is enabled or when every pin is an output. What only the bench scenarios can show is the full interplay over time: read-back from every address, the exact two-edge delay from a pad change to a read or an interrupt, and the interrupt rising and falling as enables, direction and pin levels change in turn. A long random phase also compares everything against the reference model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        ADR_PINS    = 3'd0,
        ADR_DIR     = 3'd1,
        ADR_SET     = 3'd2,
        ADR_CLR     = 3'd3,
        ADR_TGL     = 3'd4,
        ADR_IEN_SET = 3'd5,
        ADR_IEN_CLR = 3'd6,
        ADR_RSVD    = 3'd7
    } gpio_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;

    // R7: second stage always carries the first stage one edge later
    p_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));

endmodule

// File: rtl/gpio_wom_reg.sv
module gpio_wom_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    input  logic [W-1:0] tgl_m,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } wom_t;

    wom_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = (st_q.val | set_m) & ~clr_m;
        st_d.val = st_d.val ^ tgl_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0 && clr_m == '0 && tgl_m == '0) |=> q == ($past(q) | $past(set_m)));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m != '0 && set_m == '0 && tgl_m == '0) |=> q == ($past(q) & ~$past(clr_m)));

    p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_m != '0 && set_m == '0 && clr_m == '0) |=> q == ($past(q) ^ $past(tgl_m)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m == '0 && clr_m == '0 && tgl_m == '0) |=> $stable(q));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] is_out,
    output logic         irq
);

    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = level[i] & enable[i] & ~is_out[i];
    end

    assign irq = |hit;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [PINS-1:0] bus_wdata,
    output logic [PINS-1:0] bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            irq
);

    localparam logic [PINS-1:0] NONE = '0;

    typedef struct packed {
        logic [PINS-1:0] dir;
    } port_t;

    port_t           st_d, st_q;
    gpio_addr_e      adr;
    logic [PINS-1:0] out_set, out_clr, out_tgl;
    logic [PINS-1:0] ien_set, ien_clr;
    logic [PINS-1:0] out_q, ien_q, lvl;

    assign adr = gpio_addr_e'(bus_addr);

    always_comb begin
        st_d    = st_q;
        out_set = NONE;
        out_clr = NONE;
        out_tgl = NONE;
        ien_set = NONE;
        ien_clr = NONE;
        if (bus_wr) begin
            unique case (adr)
                ADR_DIR:     st_d.dir = bus_wdata;
                ADR_SET:     out_set  = bus_wdata;
                ADR_CLR:     out_clr  = bus_wdata;
                ADR_TGL:     out_tgl  = bus_wdata;
                ADR_IEN_SET: ien_set  = bus_wdata;
                ADR_IEN_CLR: ien_clr  = bus_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (adr)
            ADR_PINS:                     bus_rdata = lvl;
            ADR_DIR:                      bus_rdata = st_q.dir;
            ADR_SET, ADR_CLR, ADR_TGL:    bus_rdata = out_q;
            ADR_IEN_SET, ADR_IEN_CLR:     bus_rdata = ien_q;
            default:                      bus_rdata = NONE;
        endcase
    end

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_in),
        .level (lvl)
    );

    gpio_wom_reg #(.W(PINS)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (out_set),
        .clr_m (out_clr),
        .tgl_m (out_tgl),
        .q     (out_q)
    );

    gpio_wom_reg #(.W(PINS)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (ien_set),
        .clr_m (ien_clr),
        .tgl_m (NONE),
        .q     (ien_q)
    );

    gpio_irq_merge #(.W(PINS)) u_irq (
        .level  (lvl),
        .enable (ien_q),
        .is_out (st_q.dir),
        .irq    (irq)
    );

    assign pad_out = out_q;
    assign pad_oe  = st_q.dir;

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> pad_oe == $past(bus_wdata));

    p_dead_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd7))
        |=> ($stable(pad_out) && $stable(pad_oe)));

    p_out_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&pad_oe) |-> !irq);

    p_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == NONE) |-> !irq);

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model
    logic [N-1:0] m_out, m_dir, m_ien;
    logic [N-1:0] m_hist[$];

    always #4 clk = ~clk;

    gpio_port #(.PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [N-1:0] m_level();
        return m_hist[0];
    endfunction

    function automatic logic [N-1:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:             return m_level();
            3'd1:             return m_dir;
            3'd2, 3'd3, 3'd4: return m_out;
            3'd5, 3'd6:       return m_ien;
            default:          return '0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("pad_out", pad_out, m_out);
        chk("pad_oe", pad_oe, m_dir);
        chk("irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_level() & m_ien & ~m_dir)});
        chk("rdata", bus_rdata, m_read(bus_addr));
    endtask

    // one bus cycle: drive at negedge, compare, then advance model at posedge
    task automatic cyc(input logic [2:0] a, input logic w, input logic [N-1:0] d, input logic [N-1:0] p);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; pad_in = p;
        #1;
        compare_all();
        @(posedge clk);
        if (w) begin
            case (a)
                3'd1: m_dir = d;
                3'd2: m_out = m_out | d;
                3'd3: m_out = m_out & ~d;
                3'd4: m_out = m_out ^ d;
                3'd5: m_ien = m_ien | d;
                3'd6: m_ien = m_ien & ~d;
                default: ;
            endcase
        end
        m_hist.push_back(p);
        void'(m_hist.pop_front());
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pins;
        m_out = '0; m_dir = '0; m_ien = '0;
        m_hist = {16'h0, 16'h0};
        pins = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1'b1;
        cyc(3'd5, 0, '0, '0);

        cur_req = "R2";
        cyc(3'd1, 1, 16'h00FF, '0);
        cyc(3'd1, 0, '0, '0);

        cur_req = "R3";
        cyc(3'd2, 1, 16'h0F0F, '0);
        cyc(3'd2, 1, 16'h0100, '0);
        cur_req = "R6";
        cyc(3'd2, 0, '0, '0);

        cur_req = "R4";
        cyc(3'd3, 1, 16'h0003, '0);
        cyc(3'd3, 0, '0, '0);

        cur_req = "R5";
        cyc(3'd4, 1, 16'hFFFF, '0);
        cyc(3'd4, 1, 16'h0005, '0);
        cyc(3'd4, 0, '0, '0);

        cur_req = "R7";
        cyc(3'd0, 0, '0, 16'hA5A5);
        cyc(3'd0, 0, '0, 16'hA5A5);
        cyc(3'd0, 0, '0, 16'h5A5A);
        cyc(3'd0, 0, '0, 16'h5A5A);
        cyc(3'd0, 0, '0, 16'hA5A5);

        cur_req = "R8";
        cyc(3'd5, 1, 16'hFF00, 16'hA5A5);
        cyc(3'd6, 0, '0, 16'hA5A5);
        cur_req = "R9";
        cyc(3'd0, 0, '0, 16'hA5A5);
        cyc(3'd0, 0, '0, 16'h0000);
        cyc(3'd0, 0, '0, 16'h0000);
        cyc(3'd0, 0, '0, 16'h0000);
        cyc(3'd0, 0, '0, 16'h8000);
        cyc(3'd0, 0, '0, 16'h8000);
        cyc(3'd0, 0, '0, 16'h8000);
        cur_req = "R8";
        cyc(3'd6, 1, 16'hFF00, 16'h8000);
        cyc(3'd5, 0, '0, 16'h8000);

        cur_req = "R10";
        cyc(3'd5, 1, 16'h0001, 16'h0001);
        cyc(3'd0, 0, '0, 16'h0001);
        cyc(3'd0, 0, '0, 16'h0001);
        cyc(3'd1, 1, 16'hFFFF, 16'h0001);
        cyc(3'd0, 0, '0, 16'h0001);
        cur_req = "R9";
        cyc(3'd1, 1, 16'h0000, 16'h0001);
        cyc(3'd0, 0, '0, 16'h0001);

        cur_req = "R11";
        cyc(3'd0, 1, 16'hFFFF, 16'h0001);
        cyc(3'd7, 1, 16'hFFFF, 16'h0001);
        cyc(3'd7, 0, '0, 16'h0001);
        cyc(3'd2, 0, '0, 16'h0001);

        cur_req = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random";
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) pins = N'($urandom);
            cyc(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), N'($urandom), pins);
        end
        cyc(3'd0, 0, '0, pins);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule